// File: doc/BRIEF.md
# PS/2 Keyboard Receiver with Clock Inhibit

This block receives scan-code bytes from a PS/2 keyboard. Traffic runs one way only, from the keyboard into the block, and no commands are sent back to the keyboard. Both keyboard lines are brought into the system clock domain through a synchronizer chain. A frame state machine then steps on each falling edge of the keyboard clock. It collects the start bit, the eight data bits, the odd parity bit and the stop bit. A frame is accepted only when its parity and stop bit are both correct. An accepted byte goes into a read-only hold register, and a ready flag is raised.

While the ready flag is set, the block drives the open-drain keyboard clock line low. This stops the keyboard from sending more data until the host has taken the byte, which gives hardware flow control with no buffer. The host reads through a read strobe and a one-bit register select. Reading the data register clears the flag and releases the line. The status register carries the ready flag in bit 0, and bits 7:1 of the current byte above it.

The frame state machine has four states:

- `ST_IDLE` waits for a falling edge with data low, which is a start bit; it then goes to `ST_DATA`.
- `ST_DATA` shifts in eight bits, LSB first; after the eighth it goes to `ST_PAR`.
- `ST_PAR` captures the parity bit and goes to `ST_STOP`.
- `ST_STOP` checks the stop bit and the parity on the next edge and always returns to `ST_IDLE`.

From `ST_DATA`, `ST_PAR` and `ST_STOP` there is also a timeout transition back to `ST_IDLE`. It is taken when `TIMEOUT_CYC` system cycles pass with no keyboard clock edge; the default is about 2 ms at 50 MHz.

Top module: `kbd_rx_inhibit`

## Requirements
- R1: After reset the data register reads 0x00, the status register reads 0x00, `kbd_clk_oe` is 0 (line released) and the frame state machine is in `ST_IDLE`.
- R2: A frame is sampled on synchronized falling edges of the keyboard clock. It consists of a start bit 0, eight data bits LSB first, an odd parity bit and a stop bit 1. In `ST_IDLE`, a falling edge with data high does not start a frame.
- R3: A frame whose parity bit does not make the total count of ones across the data bits and the parity bit odd is discarded. The ready flag stays 0 and the line stays released.
- R4: An accepted byte is stored in the data register, and status bit 0 (ready) becomes 1. The data register is read with `rd_sel`=0 and the status register with `rd_sel`=1.
- R5: While ready is 1, `kbd_clk_oe` is 1, which pulls the keyboard clock low. Ready and the stored byte hold until the data register is read. Reads of the status register do not clear ready.
- R6: A read strobe with `rd_sel`=0 clears ready and releases the line from the next cycle on. In that same cycle, `rd_data` returns the stored byte.
- R7: Status bits 7:1 equal data register bits 7:1.
- R8: A frame whose stop bit is 0 is discarded, and the ready flag stays 0.
- R9: Mid-frame, if `TIMEOUT_CYC` cycles pass without a falling edge, the state machine returns to `ST_IDLE` and the partial frame is dropped. A following complete frame is then received correctly.
- R10: If a frame completes in the same cycle as a data-register read, that read returns the previous byte. The new byte is loaded, and ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kbd_clk_i | input | 1 | Sensed level of the keyboard clock line |
| kbd_dat_i | input | 1 | Keyboard data line |
| kbd_clk_oe | output | 1 | 1 = drive the keyboard clock line low (inhibit) |
| rd_stb | input | 1 | Host read strobe, one cycle per read |
| rd_sel | input | 1 | Register select: 0 = data, 1 = status |
| rd_data | output | 8 | Read data for the selected register |

## Verification
Two events can fall in the same cycle: a frame completing and the host reading the data register. Together they decide whether a byte is lost or the flag is wrongly cleared. The bench provokes this by counting cycles from the point where it drives the stop-bit falling edge. It raises the data read strobe exactly in the cycle in which the synchronized edge completes the frame. It then judges the outcome at the ports: the read must return the older byte, and afterwards the line must stay inhibited with the new byte readable.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_PAR  = 2'd2,
        ST_STOP = 2'd3
    } rx_state_t;
endpackage

// File: rtl/kbd_line_sync.sv
module kbd_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic fall_o
);
    // chain[STAGES-1] is the synchronized level; chain[STAGES] is its previous value
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-1:0], line_i};
    end

    assign level_o = chain_q[STAGES-1];
    assign fall_o  = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/kbd_frame_fsm.sv
module kbd_frame_fsm
    import kbd_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              dat_i,
    output logic [DATA_W-1:0] byte_o,
    output logic              byte_valid_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(DATA_W - 1);
    localparam logic [TMO_W-1:0] TMO_LIMIT = TMO_W'(TIMEOUT_CYC);

    rx_state_t         state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic              par_q;
    logic [TMO_W-1:0]  tmo_q;
    logic              tmo_hit;
    logic              par_ok;

    assign tmo_hit = (state_q != ST_IDLE) && (tmo_q == TMO_LIMIT);
    assign par_ok  = ^{shreg_q, par_q};
    assign byte_o  = shreg_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: an edge takes priority over the timeout
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (fall_i && !dat_i) state_d = ST_DATA;
            ST_DATA: begin
                if (fall_i) begin
                    if (bit_cnt_q == LAST_BIT) state_d = ST_PAR;
                end else if (tmo_hit) begin
                    state_d = ST_IDLE;
                end
            end
            ST_PAR: begin
                if (fall_i)       state_d = ST_STOP;
                else if (tmo_hit) state_d = ST_IDLE;
            end
            ST_STOP: begin
                if (fall_i || tmo_hit) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        byte_valid_o = 1'b0;
        unique case (state_q)
            ST_STOP: byte_valid_o = fall_i && dat_i && par_ok;
            default: byte_valid_o = 1'b0;
        endcase
    end

    // datapath: shift register, bit counter, parity, timeout counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            bit_cnt_q <= '0;
            par_q     <= 1'b0;
            tmo_q     <= '0;
        end else begin
            if (state_q == ST_IDLE || fall_i) tmo_q <= '0;
            else if (!tmo_hit)                tmo_q <= tmo_q + 1'b1;
            if (fall_i) begin
                case (state_q)
                    ST_IDLE: bit_cnt_q <= '0;
                    ST_DATA: begin
                        shreg_q   <= {dat_i, shreg_q[DATA_W-1:1]};
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end
                    ST_PAR:  par_q <= dat_i;
                    default: ;
                endcase
            end
        end
    end

    // R2
    idle_high_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && fall_i && dat_i) |=> (state_q == ST_IDLE));

    // R9
    timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_hit && !fall_i) |=> (state_q == ST_IDLE));

    // R8
    stop_low_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && fall_i && !dat_i) |-> !byte_valid_o);
endmodule

// File: rtl/kbd_hold_reg.sv
module kbd_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              clr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              ready_o
);
    logic [DATA_W-1:0] data_q;
    logic              ready_q;
    logic              take;

    // a byte is taken when the register is free or is being emptied this cycle
    assign take = load_i && (!ready_q || clr_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            ready_q <= 1'b0;
        end else if (take) begin
            data_q  <= byte_i;
            ready_q <= 1'b1;
        end else if (clr_i) begin
            ready_q <= 1'b0;
        end
    end

    assign data_o  = data_q;
    assign ready_o = ready_q;

    // R4
    load_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !ready_q) |=> (ready_q && data_q == $past(byte_i)));

    // R5
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_q && !clr_i) |=> (ready_q && $stable(data_q)));

    // R6
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !load_i) |=> !ready_q);

    // R10
    collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && load_i) |=> ready_q);
endmodule

// File: rtl/kbd_rx_inhibit.sv
module kbd_rx_inhibit #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kbd_clk_i,
    input  logic              kbd_dat_i,
    output logic              kbd_clk_oe,
    input  logic              rd_stb,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data
);
    logic              clk_level;
    logic              clk_fall;
    logic              dat_level;
    logic              dat_fall;
    logic [DATA_W-1:0] rx_byte;
    logic              rx_valid;
    logic [DATA_W-1:0] held;
    logic              ready;
    logic              data_read;

    kbd_line_sync #(.STAGES(SYNC_STAGES)) u_clk_sync (
        .clk(clk), .rst_n(rst_n), .line_i(kbd_clk_i),
        .level_o(clk_level), .fall_o(clk_fall)
    );

    kbd_line_sync #(.STAGES(SYNC_STAGES)) u_dat_sync (
        .clk(clk), .rst_n(rst_n), .line_i(kbd_dat_i),
        .level_o(dat_level), .fall_o(dat_fall)
    );

    kbd_frame_fsm #(.DATA_W(DATA_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .fall_i(clk_fall), .dat_i(dat_level),
        .byte_o(rx_byte), .byte_valid_o(rx_valid)
    );

    assign data_read = rd_stb && !rd_sel;

    kbd_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .load_i(rx_valid), .byte_i(rx_byte),
        .clr_i(data_read), .data_o(held), .ready_o(ready)
    );

    assign kbd_clk_oe = ready;
    assign rd_data    = rd_sel ? {held[DATA_W-1:1], ready} : held;

    // the data line's edge is not used; the synchronized clock level is sensed only for edges
    logic unused_ok;
    assign unused_ok = ^{dat_fall, clk_level};

    // R7
    status_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel |-> (rd_data[DATA_W-1:1] == held[DATA_W-1:1]));

    // R5
    inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_clk_oe && !data_read) |=> kbd_clk_oe);
endmodule

// File: tb/sim_kbd_rx_inhibit.sv
module sim_kbd_rx_inhibit;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int TMO        = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kbd_drv = 1'b1;
    logic       kbd_dat = 1'b1;
    logic       rd_stb = 1'b0;
    logic       rd_sel = 1'b0;
    logic       kbd_clk_oe;
    logic [7:0] rd_data;
    logic       kbd_line;

    int         checks = 0;
    int         errors = 0;
    bit         auto_rd = 1'b0;
    logic [7:0] exp_q[$];
    logic [7:0] stale;

    assign kbd_line = kbd_drv & ~kbd_clk_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    kbd_rx_inhibit #(.DATA_W(8), .SYNC_STAGES(2), .TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .kbd_clk_i(kbd_line), .kbd_dat_i(kbd_dat),
        .kbd_clk_oe(kbd_clk_oe), .rd_stb(rd_stb), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // driver: sends one frame and pushes the expected byte to the scoreboard
    task automatic send_frame(input logic [7:0] b, input bit bad_par, input bit bad_stop,
                              input bit collide, input bit push);
        logic [10:0] bits;
        while (kbd_clk_oe) @(negedge clk);
        bits = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
        if (push) exp_q.push_back(b);
        for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            kbd_dat = bits[i];
            ticks(HALF);
            kbd_drv = 1'b0;
            if (collide && i == 10) begin
                ticks(2);
                rd_sel = 1'b0;
                rd_stb = 1'b1;
                stale  = rd_data;
                ticks(1);
                rd_stb = 1'b0;
                ticks(HALF - 3);
            end else begin
                ticks(HALF);
            end
            kbd_drv = 1'b1;
        end
        kbd_dat = 1'b1;
    endtask

    task automatic drain();
        for (int k = 0; k < 3000 && exp_q.size() != 0; k++) @(negedge clk);
        chk("R4 scoreboard drained", 8'(exp_q.size()), 8'd0);
    endtask

    // monitor: reads out each byte the design presents and compares with the scoreboard
    always begin
        @(negedge clk);
        if (auto_rd && kbd_clk_oe) begin
            logic [7:0] e;
            if (exp_q.size() == 0) begin
                chk("R3/R8 unexpected byte", 8'h01, 8'h00);
                e = 8'h00;
            end else begin
                e = exp_q.pop_front();
            end
            rd_sel = 1'b1;
            #1;
            chk("R7 status mirror and R4 ready", rd_data, {e[7:1], 1'b1});
            rd_sel = 1'b0;
            #1;
            chk("R4 data value", rd_data, e);
            rd_stb = 1'b1;
            @(negedge clk);
            rd_stb = 1'b0;
            chk("R6 line released after read", {7'd0, kbd_clk_oe}, 8'd0);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hang expected=done");
        summary();
    end

    initial begin
        ticks(3);
        rst_n = 1'b1;
        ticks(2);
        // R1 reset state
        rd_sel = 1'b0; #1;
        chk("R1 data after reset", rd_data, 8'h00);
        rd_sel = 1'b1; #1;
        chk("R1 status after reset", rd_data, 8'h00);
        chk("R1 line released", {7'd0, kbd_clk_oe}, 8'd0);

        // R2 a lone high-data edge in idle starts nothing; good bytes follow
        kbd_dat = 1'b1;
        ticks(2); kbd_drv = 1'b0; ticks(HALF); kbd_drv = 1'b1; ticks(HALF);
        auto_rd = 1'b1;
        send_frame(8'hA5, 0, 0, 0, 1); drain();
        send_frame(8'h00, 0, 0, 0, 1); drain();
        send_frame(8'hFF, 0, 0, 0, 1); drain();
        send_frame(8'h1C, 0, 0, 0, 1); drain();

        // R3 bad parity discarded
        send_frame(8'h66, 1, 0, 0, 0);
        ticks(20);
        rd_sel = 1'b1; #1;
        chk("R3 ready stays 0 after bad parity", {7'd0, rd_data[0]}, 8'd0);
        chk("R3 line stays released", {7'd0, kbd_clk_oe}, 8'd0);

        // R8 bad stop bit discarded
        send_frame(8'h81, 0, 1, 0, 0);
        ticks(20);
        chk("R8 ready stays 0 after bad stop", {7'd0, kbd_clk_oe}, 8'd0);

        // R9 partial frame times out, next frame is clean
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); kbd_dat = (i == 0) ? 1'b0 : 1'b1;
            ticks(HALF); kbd_drv = 1'b0; ticks(HALF); kbd_drv = 1'b1;
        end
        kbd_dat = 1'b1;
        ticks(TMO + 50);
        chk("R9 partial frame gives no byte", {7'd0, kbd_clk_oe}, 8'd0);
        send_frame(8'h3C, 0, 0, 0, 1); drain();

        // R5 inhibit holds until the data register is read
        auto_rd = 1'b0;
        send_frame(8'h5A, 0, 0, 0, 0);
        ticks(100);
        chk("R5 line held low", {7'd0, kbd_clk_oe}, 8'd1);
        rd_sel = 1'b1; rd_stb = 1'b1; ticks(1); rd_stb = 1'b0; ticks(1);
        chk("R5 status read keeps ready", {7'd0, kbd_clk_oe}, 8'd1);
        rd_sel = 1'b1; #1;
        chk("R7 status mirror 0x5A", rd_data, 8'h5B);
        rd_sel = 1'b0; #1;
        chk("R6 data read returns byte", rd_data, 8'h5A);
        rd_stb = 1'b1; ticks(1); rd_stb = 1'b0;
        chk("R6 line released after data read", {7'd0, kbd_clk_oe}, 8'd0);
        rd_sel = 1'b1; #1;
        chk("R6 ready cleared", {7'd0, rd_data[0]}, 8'd0);

        // R10 completion and data read in the same cycle
        send_frame(8'hC3, 0, 0, 1, 0);
        chk("R10 colliding read returns previous byte", stale, 8'h5A);
        ticks(2);
        chk("R10 ready stays set", {7'd0, kbd_clk_oe}, 8'd1);
        rd_sel = 1'b0; #1;
        chk("R10 new byte loaded", rd_data, 8'hC3);
        rd_stb = 1'b1; ticks(1); rd_stb = 1'b0;
        chk("R6 release after collide", {7'd0, kbd_clk_oe}, 8'd0);

        auto_rd = 1'b1;
        send_frame(8'h96, 0, 0, 0, 1); drain();
        ticks(10);
        summary();
    end
endmodule